// File: doc/BRIEF.md
# Mode-Selectable Serial Baud Tick Generator

This block produces the bit-rate timing for a serial port. A divisor value `n` is held as two byte-wide halves, each loaded through its own write strobe. A down-counter runs from `n` to zero and reloads, so it emits one underflow pulse every `n+1` clock cycles. A prescaler then divides that pulse train by 64, 16 or 4 to form the bit-rate tick.

Three mode inputs select the prescale factor and whether the counter uses the full 16-bit divisor or only the low byte. The inputs are synchronous operation, 16-bit counting and high-speed prescale. The raw underflow pulse is also brought out, for a receiver that oversamples the line. Writing either divisor byte restarts both the counter and the prescaler at once, so a new rate takes effect cleanly.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tick` and `raw_tick` are 0 after that edge. Both divisor bytes are cleared.
- R2: With `mode_sync`=0, `mode_wide`=0 and `mode_fast`=0, `tick` pulses once every 64·(n+1) cycles.
- R3: With `mode_sync`=0, `mode_wide`=0 and `mode_fast`=1, `tick` pulses once every 16·(n+1) cycles.
- R4: With `mode_sync`=0, `mode_wide`=1 and `mode_fast`=0, `tick` pulses once every 16·(n+1) cycles.
- R5: With `mode_sync`=0, `mode_wide`=1 and `mode_fast`=1, `tick` pulses once every 4·(n+1) cycles.
- R6: With `mode_sync`=1, `tick` pulses once every 4·(n+1) cycles. This holds for either value of `mode_wide`, and `mode_fast` has no effect.
- R7: When `mode_wide`=0, n is the low byte alone, and the stored high byte has no effect on either output rate.
- R8: When `mode_wide`=1, n = {high byte, low byte}, with the high byte in bits 15:8. A byte changes only in a cycle where its write strobe is high.
- R9: A write to either byte restarts the count. Both outputs are 0 after the write edge. The first `raw_tick` comes n+1 edges after the write edge, and the first `tick` comes P·(n+1)+1 edges after it, where P is the prescale factor of R2 to R6.
- R10: Each `tick` pulse is exactly one clock cycle wide.
- R11: `raw_tick` pulses once every n+1 cycles. For n=0 it is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_lo | input | 8 | Divisor low byte write data |
| div_lo_we | input | 1 | Low byte write strobe |
| div_hi | input | 8 | Divisor high byte write data |
| div_hi_we | input | 1 | High byte write strobe |
| mode_sync | input | 1 | Synchronous mode: prescale by 4 |
| mode_wide | input | 1 | Use the full 16-bit divisor |
| mode_fast | input | 1 | High-speed prescale in asynchronous mode |
| tick | output | 1 | One-cycle bit-rate tick |
| raw_tick | output | 1 | One-cycle counter underflow pulse |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 16-bit divisor and prescale factors 64, 16 and 4. With these values the bench reaches every row of the mode table, including a divisor above 255 that depends on the high byte. It also measures the slowest prescale path, the n=0 case where the underflow pulse is high on every cycle, and a restart caused by a write to a single byte in the middle of a count. In each case the bench times the first two underflows and the first two ticks from the write edge.

// File: rtl/baudgen_pkg.sv
// Shared types for the baud tick generator.
// Assumes: used only by the baud_tick_gen hierarchy.
package baudgen_pkg;

    // Mode bits as presented at the block inputs.
    typedef struct packed {
        logic sync;
        logic wide;
        logic fast;
    } bg_mode_t;

    // Which prescale factor applies.
    typedef enum logic [1:0] {
        PS_SLOW = 2'd0,
        PS_MID  = 2'd1,
        PS_FAST = 2'd2
    } bg_presel_t;

    // Maps the mode bits onto a prescale choice.
    function automatic bg_presel_t presel_of(input bg_mode_t m);
        bg_presel_t r;
        if (m.sync)                r = PS_FAST;
        else if (m.wide && m.fast) r = PS_FAST;
        else if (m.wide || m.fast) r = PS_MID;
        else                       r = PS_SLOW;
        return r;
    endfunction

endpackage

// File: rtl/bg_divisor_regs.sv
// Divisor storage: NBYTES byte lanes, each with its own write strobe.
// It presents the stored value and the value visible after this edge.
// Assumes: strobes are single-cycle or level; last write wins per lane.
module bg_divisor_regs #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int DW    = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NBYTES-1:0] we_i,
    output logic [DW-1:0]     div_o,
    output logic [DW-1:0]     div_next_o,
    output logic              load_o
);

    logic [DW-1:0] div_q;

    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_lane
            // Purpose: hold one byte of the divisor.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_q[g*BYTE_W +: BYTE_W] <= '0;
                else if (we_i[g])
                    div_q[g*BYTE_W +: BYTE_W] <= wdata_i[g*BYTE_W +: BYTE_W];
            end

            // Purpose: the value that the lane holds after this edge.
            assign div_next_o[g*BYTE_W +: BYTE_W] =
                we_i[g] ? wdata_i[g*BYTE_W +: BYTE_W] : div_q[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    assign div_o  = div_q;
    assign load_o = |we_i;

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|we_i) |=> $stable(div_q));

endmodule

// File: rtl/bg_count.sv
// Down-counter: loads n, counts to zero, then reloads and pulses uflow_o.
// It gives one pulse every n+1 cycles. In narrow mode only the low byte
// reloads. Assumes load_i comes from a divisor write.
module bg_count #(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             wide_i,
    input  logic [DIV_W-1:0] div_next_i,
    output logic             uflow_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload;
    logic             uflow_q;

    // Purpose: pick the reload value for the selected counter width.
    always_comb begin
        if (wide_i) reload = div_next_i;
        else        reload = {{(DIV_W-BYTE_W){1'b0}}, div_next_i[BYTE_W-1:0]};
    end

    // Purpose: count down, reload at zero or on a divisor write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            uflow_q <= 1'b0;
        end else if (load_i) begin
            cnt_q   <= reload;
            uflow_q <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q   <= reload;
            uflow_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q - 1'b1;
            uflow_q <= 1'b0;
        end
    end

    assign uflow_o = uflow_q;

    // R9
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !uflow_o);

    // R11
    uflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_o |-> $past(cnt_q == '0));

endmodule

// File: rtl/bg_prescale.sv
// Prescaler: divides the underflow pulse train by the selected factor.
// It emits a one-cycle tick. Assumes factors are powers of two that fit
// in PRE_W bits; a count beyond a new, smaller terminal wraps at once.
module bg_prescale #(
    parameter int PRE_SLOW = 64,
    parameter int PRE_MID  = 16,
    parameter int PRE_FAST = 4,
    localparam int PRE_W   = $clog2(PRE_SLOW)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart_i,
    input  logic                     uflow_i,
    input  baudgen_pkg::bg_presel_t  sel_i,
    output logic                     tick_o
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] term;
    logic             tick_q;

    // Purpose: terminal count for the chosen factor.
    always_comb begin
        case (sel_i)
            baudgen_pkg::PS_FAST: term = PRE_W'(PRE_FAST - 1);
            baudgen_pkg::PS_MID:  term = PRE_W'(PRE_MID - 1);
            default:              term = PRE_W'(PRE_SLOW - 1);
        endcase
    end

    // Purpose: count underflows and fire the tick at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            pre_q  <= '0;
            tick_q <= 1'b0;
        end else if (uflow_i) begin
            if (pre_q >= term) begin
                pre_q  <= '0;
                tick_q <= 1'b1;
            end else begin
                pre_q  <= pre_q + 1'b1;
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // R10
    tick_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R2
    tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(uflow_i));

endmodule

// File: rtl/baud_tick_gen.sv
// Top: baud tick generator. It stores a divisor, selects the prescale
// factor and counter width from three mode bits, and drives the tick and
// the raw underflow pulse. Assumes a mode change is followed by a divisor
// write, so that the new setting starts from a clean count.
module baud_tick_gen #(
    parameter int BYTE_W   = 8,
    parameter int PRE_SLOW = 64,
    parameter int PRE_MID  = 16,
    parameter int PRE_FAST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic              div_lo_we,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic              div_hi_we,
    input  logic              mode_sync,
    input  logic              mode_wide,
    input  logic              mode_fast,
    output logic              tick,
    output logic              raw_tick
);

    import baudgen_pkg::*;

    localparam int NBYTES = 2;
    localparam int DIV_W  = BYTE_W * NBYTES;

    logic [DIV_W-1:0] div_cur;
    logic [DIV_W-1:0] div_next;
    logic             load;
    bg_mode_t         mode;
    bg_presel_t       presel;

    // Purpose: gather the mode bits and pick the prescale factor.
    always_comb begin
        mode   = '{sync: mode_sync, wide: mode_wide, fast: mode_fast};
        presel = presel_of(mode);
    end

    bg_divisor_regs #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdata_i    ({div_hi, div_lo}),
        .we_i       ({div_hi_we, div_lo_we}),
        .div_o      (div_cur),
        .div_next_o (div_next),
        .load_o     (load)
    );

    bg_count #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .wide_i     (mode.wide),
        .div_next_i (div_next),
        .uflow_o    (raw_tick)
    );

    bg_prescale #(.PRE_SLOW(PRE_SLOW), .PRE_MID(PRE_MID), .PRE_FAST(PRE_FAST)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load),
        .uflow_i   (raw_tick),
        .sel_i     (presel),
        .tick_o    (tick)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!tick && !raw_tick && div_cur == '0));

endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo = 8'h00, div_hi = 8'h00;
    logic       div_lo_we = 1'b0, div_hi_we = 1'b0;
    logic       mode_sync = 1'b0, mode_wide = 1'b0, mode_fast = 1'b0;
    logic       tick, raw_tick;

    int checks = 0;
    int errors = 0;
    int sh_lo  = 0;
    int sh_hi  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n),
        .div_lo(div_lo), .div_lo_we(div_lo_we),
        .div_hi(div_hi), .div_hi_we(div_hi_we),
        .mode_sync(mode_sync), .mode_wide(mode_wide), .mode_fast(mode_fast),
        .tick(tick), .raw_tick(raw_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic s, input logic w, input logic f);
        @(negedge clk);
        mode_sync = s; mode_wide = w; mode_fast = f;
    endtask

    // Write, then time the first two underflows and the first two ticks.
    task automatic write_and_measure(input string req, input bit we_hi, input bit we_lo,
                                     input int hi, input int lo, input int p);
        int n, k, u1, u2, t1, t2, wide_fail, prev_t, limit;
        @(negedge clk);
        div_hi = 8'(hi); div_lo = 8'(lo);
        div_hi_we = we_hi; div_lo_we = we_lo;
        if (we_hi) sh_hi = hi;
        if (we_lo) sh_lo = lo;
        n = mode_wide ? (sh_hi * 256 + sh_lo) : sh_lo;
        @(posedge clk);
        @(negedge clk);
        div_hi_we = 1'b0; div_lo_we = 1'b0;
        // R9: quiet right after the write edge
        check({req, " R9 quiet after write"}, int'(tick) + int'(raw_tick), 0);
        k = 0; u1 = -1; u2 = -1; t1 = -1; t2 = -1; wide_fail = 0; prev_t = 0;
        limit = 2 * p * (n + 1) + 20;
        while (t2 < 0 && k < limit) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (raw_tick) begin
                if (u1 < 0) u1 = k;
                else if (u2 < 0) u2 = k;
            end
            if (tick && prev_t != 0) wide_fail++;
            if (tick && prev_t == 0) begin
                if (t1 < 0) t1 = k;
                else if (t2 < 0) t2 = k;
            end
            prev_t = int'(tick);
        end
        // R9 / R11
        check({req, " R9 first raw_tick"}, u1, n + 1);
        check({req, " R11 raw_tick period"}, u2 - u1, n + 1);
        // R9
        check({req, " R9 first tick"}, t1, p * (n + 1) + 1);
        check({req, " tick period"}, t2 - t1, p * (n + 1));
        // R10
        check({req, " R10 tick width"}, wide_fail, 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check("R1 tick in reset", int'(tick), 0);
        check("R1 raw_tick in reset", int'(raw_tick), 0);
        @(negedge clk);
        rst_n = 1'b1;
        sh_hi = 0; sh_lo = 0;
    endtask

    task automatic test_async_narrow_slow();
        set_mode(0, 0, 0);
        write_and_measure("R2", 1, 1, 8'hAA, 3, 64);
    endtask

    task automatic test_async_narrow_fast();
        set_mode(0, 0, 1);
        write_and_measure("R3", 1, 1, 0, 9, 16);
    endtask

    task automatic test_async_wide_slow();
        set_mode(0, 1, 0);
        write_and_measure("R4 R8", 1, 1, 1, 2, 16);
    endtask

    task automatic test_async_wide_fast();
        set_mode(0, 1, 1);
        write_and_measure("R5 R8", 1, 1, 1, 0, 4);
    endtask

    task automatic test_sync();
        set_mode(1, 0, 1);
        write_and_measure("R6 narrow fast", 1, 1, 7, 5, 4);
        set_mode(1, 1, 0);
        write_and_measure("R6 wide", 1, 1, 1, 1, 4);
    endtask

    task automatic test_high_ignored();
        set_mode(0, 0, 1);
        write_and_measure("R7 n0", 1, 1, 8'hFF, 0, 16);
        write_and_measure("R7 hi only", 1, 0, 8'h3C, 0, 16);
    endtask

    task automatic test_restart();
        set_mode(0, 1, 1);
        write_and_measure("R9 setup", 1, 1, 0, 40, 4);
        repeat (17) @(posedge clk);
        write_and_measure("R9 hi write", 1, 0, 1, 0, 4);
        repeat (5) @(posedge clk);
        write_and_measure("R9 lo write", 0, 1, 0, 7, 4);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        test_reset();
        test_async_narrow_slow();
        test_async_narrow_fast();
        test_async_wide_slow();
        test_async_wide_fast();
        test_sync();
        test_high_ignored();
        test_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule